// File: doc/BRIEF.md
# Circular Queue Pointer Pair with Wrap Flag

This block holds the producer and consumer positions of a circular queue that lives in system memory. The queue depth is a power of two chosen at run time through a log2 size input. Each position carries one extra bit above the slot index. That wrap flag toggles each time the index passes the end of the ring, so a full ring and an empty ring never look the same. Software or a bus decoder writes either position directly. Queue agents advance them with single-cycle increment strobes.

The consumer register also carries a 7-bit error code in bits 30:24, which a consumer write sets. Consumer increments leave that code alone. For each position the block also produces the memory address of the slot it points to. That address is the queue base, aligned down to 64 bytes, plus the slot index times the entry size. The entry size is a parameter: 16 bytes for a command ring, 32 bytes for an event ring. All outputs are registered.

Top module: `wq_ring_ptrs`

## Requirements
- R1: While reset is high, both position registers and the error code read zero, `q_empty` is 1, `q_full` and `proto_err` are 0, and both slot addresses are 0.
- R2: The log2 size is captured on every clock edge at which `q_en` is low, and clamped to MAX_LOG2. While `q_en` is high, changes on `log2_size` have no effect.
- R3: `q_empty` is 1 exactly when the two positions agree in all of their low L+1 bits, where L is the captured log2 size.
- R4: `q_full` is 1 exactly when the two slot indices (bits L-1:0) agree and the wrap flags (bit L) differ.
- R5: A producer increment adds one modulo 2^(L+1), so after 2*depth increments the position returns to zero.
- R6: A consumer increment changes only the low L+1 bits of `cons_reg`. The error code in bits 30:24 stays as it was.
- R7: Each slot address equals (`base_addr` with bits 5:0 cleared) plus ENTRY_BYTES times the low L bits of the matching position, truncated to ADDR_W bits.
- R8: A producer write stores the low L+1 bits of `prod_wdata`. A consumer write stores the low L+1 bits of `cons_wdata` as the position and bits 30:24 as the error code. All other register bits read zero.
- R9: A producer increment while full, or a consumer increment while empty, leaves that position unchanged and raises `proto_err` for exactly one cycle. `proto_err` never rises without such an increment.
- R10: Producer and consumer increments in the same cycle both take effect. A write and an increment to the same position in the same cycle store the written value, with no error pulse.
- R11: Every output changes on the clock edge that samples the stimulus and is stable for the rest of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_en | input | 1 | Queue enabled; low lets the log2 size be captured |
| log2_size | input | LOG2_W | Requested log2 of the queue depth |
| base_addr | input | ADDR_W | Queue base address in memory |
| prod_wr | input | 1 | Producer register write strobe |
| prod_wdata | input | 32 | Producer write data |
| cons_wr | input | 1 | Consumer register write strobe |
| cons_wdata | input | 32 | Consumer write data, error code in bits 30:24 |
| prod_inc | input | 1 | Producer advance strobe |
| cons_inc | input | 1 | Consumer advance strobe |
| prod_reg | output | 32 | Producer register value |
| cons_reg | output | 32 | Consumer register value with error code |
| q_full | output | 1 | Ring full |
| q_empty | output | 1 | Ring empty |
| prod_slot | output | ADDR_W | Memory address of the producer slot |
| cons_slot | output | ADDR_W | Memory address of the consumer slot |
| proto_err | output | 1 | One-cycle pulse on a rejected increment |

## Verification
Two functions can fall in the same cycle. A producer and a consumer advance can arrive together, and a write can coincide with an advance of the same position. The bench raises both strobes together on a partly filled ring, and also drives a write with an increment in one cycle. The scoreboard model judges each case: both positions move in the first, the written value wins in the second, and neither case may raise the error pulse. A consumer write that plants an error code, followed by consumer advances, shows that the code survives the pointer arithmetic.

// File: rtl/wq_pkg.sv
package wq_pkg;

  localparam int REG_W       = 32;
  localparam int ERR_LSB     = 24;
  localparam int ERR_W       = 7;
  localparam int ALIGN_BITS  = 6;

  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STEP   = 2'd2,
    OP_REJECT = 2'd3
  } ptr_op_e;

  // Mask covering index plus wrap flag for a ring of 2**l slots.
  function automatic logic [31:0] span_mask(input logic [7:0] l);
    return (32'd2 << l) - 32'd1;
  endfunction

endpackage

// File: rtl/wq_size_latch.sv
module wq_size_latch #(
  parameter int MAX_LOG2 = 8,
  parameter int LOG2_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_en,
  input  logic [LOG2_W-1:0] log2_in,
  output logic [LOG2_W-1:0] l_nxt
);
  localparam logic [LOG2_W-1:0] L_CAP = LOG2_W'(MAX_LOG2);

  logic [LOG2_W-1:0] l_q;

  always_comb begin
    if (q_en)                 l_nxt = l_q;
    else if (log2_in > L_CAP) l_nxt = L_CAP;
    else                      l_nxt = log2_in;
  end

  always_ff @(posedge clk) begin
    if (rst) l_q <= '0;
    else     l_q <= l_nxt;
  end
endmodule

// File: rtl/wq_ptr_step.sv
module wq_ptr_step
  import wq_pkg::*;
#(
  parameter int PTR_W  = 9,
  parameter int LOG2_W = 4
) (
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic [LOG2_W-1:0] l,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              inc,
  input  logic              blocked,
  output ptr_op_e           op,
  output logic [PTR_W-1:0]  ptr_nxt
);
  logic [31:0]      wim32;
  logic [PTR_W-1:0] wim;
  logic [REG_W-1:0] wmasked;
  logic             unused_bits;

  assign wim32       = span_mask(8'(l));
  assign wim         = wim32[PTR_W-1:0];
  assign wmasked     = wdata & wim32;
  assign unused_bits = ^{wim32[31:PTR_W], wmasked[REG_W-1:PTR_W]};

  always_comb begin
    op      = OP_HOLD;
    ptr_nxt = ptr_q;
    if (wr) begin
      op      = OP_LOAD;
      ptr_nxt = wmasked[PTR_W-1:0];
    end else if (inc) begin
      if (blocked) begin
        op = OP_REJECT;
      end else begin
        op      = OP_STEP;
        ptr_nxt = (ptr_q + PTR_W'(1)) & wim;
      end
    end
  end
endmodule

// File: rtl/wq_slot_addr.sv
module wq_slot_addr
  import wq_pkg::*;
#(
  parameter int PTR_W       = 9,
  parameter int LOG2_W      = 4,
  parameter int ADDR_W      = 48,
  parameter int ENTRY_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  ptr_nxt,
  input  logic [LOG2_W-1:0] l_nxt,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ALIGN_BITS) - 1);

  logic [31:0]       wim32;
  logic [PTR_W-1:0]  idx;
  logic [ADDR_W-1:0] offset;
  logic              unused_bits;

  assign wim32       = span_mask(8'(l_nxt));
  assign idx         = ptr_nxt & (wim32[PTR_W-1:0] >> 1);
  assign offset      = ADDR_W'(idx) << ENTRY_SHIFT;
  assign unused_bits = ^wim32[31:PTR_W];

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= (base & ALIGN_MASK) + offset;
  end
endmodule

// File: rtl/wq_ring_ptrs.sv
module wq_ring_ptrs
  import wq_pkg::*;
#(
  parameter int MAX_LOG2    = 8,   // at most 23 so the position fits below the error code
  parameter int ADDR_W      = 48,
  parameter int ENTRY_BYTES = 16,
  parameter int LOG2_W      = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_en,
  input  logic [LOG2_W-1:0] log2_size,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              prod_wr,
  input  logic [31:0]       prod_wdata,
  input  logic              cons_wr,
  input  logic [31:0]       cons_wdata,
  input  logic              prod_inc,
  input  logic              cons_inc,
  output logic [31:0]       prod_reg,
  output logic [31:0]       cons_reg,
  output logic              q_full,
  output logic              q_empty,
  output logic [ADDR_W-1:0] prod_slot,
  output logic [ADDR_W-1:0] cons_slot,
  output logic              proto_err
);
  localparam int PTR_W = MAX_LOG2 + 1;
  localparam int NPTR  = 2;  // 0 = producer, 1 = consumer

  logic [LOG2_W-1:0] l_nxt;
  logic [PTR_W-1:0]  ptr_q   [NPTR];
  logic [PTR_W-1:0]  ptr_nxt [NPTR];
  logic [ADDR_W-1:0] slot_q  [NPTR];
  ptr_op_e           op      [NPTR];
  logic              wr_v    [NPTR];
  logic              inc_v   [NPTR];
  logic              blk_v   [NPTR];
  logic [REG_W-1:0]  wd_v    [NPTR];

  logic [ERR_W-1:0]  err_q, err_nxt;
  logic              full_q, empty_q, proto_q;
  logic              full_nxt, empty_nxt, proto_nxt;
  logic [31:0]       wim32;
  logic [PTR_W-1:0]  diff, wrap_bit;
  logic              unused_bits;

  wq_size_latch #(.MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W)) size_i (
    .clk(clk), .rst(rst), .q_en(q_en), .log2_in(log2_size), .l_nxt(l_nxt)
  );

  assign wr_v[0]  = prod_wr;     assign wr_v[1]  = cons_wr;
  assign inc_v[0] = prod_inc;    assign inc_v[1] = cons_inc;
  assign blk_v[0] = full_q;      assign blk_v[1] = empty_q;
  assign wd_v[0]  = prod_wdata;  assign wd_v[1]  = cons_wdata;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    wq_ptr_step #(.PTR_W(PTR_W), .LOG2_W(LOG2_W)) step_i (
      .ptr_q(ptr_q[g]), .l(l_nxt), .wr(wr_v[g]), .wdata(wd_v[g]),
      .inc(inc_v[g]), .blocked(blk_v[g]), .op(op[g]), .ptr_nxt(ptr_nxt[g])
    );

    wq_slot_addr #(.PTR_W(PTR_W), .LOG2_W(LOG2_W), .ADDR_W(ADDR_W),
                   .ENTRY_BYTES(ENTRY_BYTES)) addr_i (
      .clk(clk), .rst(rst), .ptr_nxt(ptr_nxt[g]), .l_nxt(l_nxt),
      .base(base_addr), .addr_q(slot_q[g])
    );

    always_ff @(posedge clk) begin
      if (rst) ptr_q[g] <= '0;
      else     ptr_q[g] <= ptr_nxt[g];
    end
  end

  // Flags judged on the next-state positions so they line up with the registers.
  assign wim32     = span_mask(8'(l_nxt));
  assign diff      = (ptr_nxt[0] ^ ptr_nxt[1]) & wim32[PTR_W-1:0];
  assign wrap_bit  = wim32[PTR_W-1:0] ^ (wim32[PTR_W-1:0] >> 1);
  assign empty_nxt = (diff == '0);
  assign full_nxt  = (diff == wrap_bit);
  assign proto_nxt = (op[0] == OP_REJECT) || (op[1] == OP_REJECT);
  assign err_nxt   = cons_wr ? cons_wdata[ERR_LSB +: ERR_W] : err_q;

  assign unused_bits = ^wim32[31:PTR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      proto_q <= 1'b0;
    end else begin
      err_q   <= err_nxt;
      full_q  <= full_nxt;
      empty_q <= empty_nxt;
      proto_q <= proto_nxt;
    end
  end

  assign prod_reg  = {{(REG_W - PTR_W){1'b0}}, ptr_q[0]};
  assign cons_reg  = {1'b0, err_q, {(ERR_LSB - PTR_W){1'b0}}, ptr_q[1]};
  assign q_full    = full_q;
  assign q_empty   = empty_q;
  assign proto_err = proto_q;
  assign prod_slot = slot_q[0];
  assign cons_slot = slot_q[1];
endmodule

// File: rtl/wq_ring_ptrs_chk.sv
module wq_ring_ptrs_chk (
  input logic        clk,
  input logic        rst,
  input logic        prod_wr,
  input logic        cons_wr,
  input logic        prod_inc,
  input logic        cons_inc,
  input logic [31:0] prod_reg,
  input logic [31:0] cons_reg,
  input logic        q_full,
  input logic        q_empty,
  input logic        proto_err
);
  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(q_full && q_empty));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q_full && prod_inc && !prod_wr) |=> (proto_err && $stable(prod_reg)));

  // R9
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q_empty && cons_inc && !cons_wr) |=> (proto_err && $stable(cons_reg)));

  // R6
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !cons_wr |=> $stable(cons_reg[30:24]));

  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!prod_inc && !cons_inc) |=> !proto_err);

  // R5
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_inc && !prod_wr && !q_full) |=> !$stable(prod_reg));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (prod_wr && cons_wr) |=> !proto_err);
endmodule

bind wq_ring_ptrs wq_ring_ptrs_chk chk_i (
  .clk(clk), .rst(rst), .prod_wr(prod_wr), .cons_wr(cons_wr),
  .prod_inc(prod_inc), .cons_inc(cons_inc), .prod_reg(prod_reg),
  .cons_reg(cons_reg), .q_full(q_full), .q_empty(q_empty),
  .proto_err(proto_err)
);

// File: tb/wq_ring_ptrs_tb_top.sv
`timescale 1ns/1ps
module wq_ring_ptrs_tb_top;
  localparam int MAX_LOG2    = 8;
  localparam int ADDR_W      = 48;
  localparam int ENTRY_BYTES = 16;
  localparam int LOG2_W      = $clog2(MAX_LOG2 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic q_en = 1'b0;
  logic [LOG2_W-1:0] log2_size = '0;
  logic [ADDR_W-1:0] base_addr = 48'h1234_5678_9ABF;
  logic prod_wr = 1'b0, cons_wr = 1'b0, prod_inc = 1'b0, cons_inc = 1'b0;
  logic [31:0] prod_wdata = '0, cons_wdata = '0;
  logic [31:0] prod_reg, cons_reg;
  logic q_full, q_empty, proto_err;
  logic [ADDR_W-1:0] prod_slot, cons_slot;

  always #2.5 clk = ~clk;

  wq_ring_ptrs #(.MAX_LOG2(MAX_LOG2), .ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)) dut_i (
    .clk(clk), .rst(rst), .q_en(q_en), .log2_size(log2_size), .base_addr(base_addr),
    .prod_wr(prod_wr), .prod_wdata(prod_wdata), .cons_wr(cons_wr), .cons_wdata(cons_wdata),
    .prod_inc(prod_inc), .cons_inc(cons_inc), .prod_reg(prod_reg), .cons_reg(cons_reg),
    .q_full(q_full), .q_empty(q_empty), .prod_slot(prod_slot), .cons_slot(cons_slot),
    .proto_err(proto_err)
  );

  typedef struct {
    int          due;
    string       tag;
    logic [31:0] p, c;
    logic        f, e, pe;
    logic [ADDR_W-1:0] ps, cs;
  } exp_t;

  exp_t sbq[$];
  int   n_checks = 0;
  int   n_errors = 0;
  int   cyc_n    = 0;

  // Reference state built from the requirements
  int          m_l = 0;
  logic [31:0] m_p = 0, m_c = 0;
  logic [6:0]  m_err = 0;
  logic        m_full = 0, m_empty = 1;

  always @(posedge clk) cyc_n <= cyc_n + 1;

  function automatic logic [31:0] span(input int l);
    return (32'd2 << l) - 32'd1;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_of(input logic [31:0] ptr, input int l);
    logic [ADDR_W-1:0] al;
    al = base_addr & ~ADDR_W'(63);
    return al + ADDR_W'((ptr & (span(l) >> 1)) * ENTRY_BYTES);
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected outputs
  task automatic cyc(input bit en, input int l, input bit pw, input logic [31:0] pd,
                     input bit cw, input logic [31:0] cd, input bit pi, input bit ci,
                     input string tag);
    exp_t x;
    logic pe;
    @(negedge clk);
    q_en = en; log2_size = LOG2_W'(l);
    prod_wr = pw; prod_wdata = pd; cons_wr = cw; cons_wdata = cd;
    prod_inc = pi; cons_inc = ci;
    if (!en) m_l = (l > MAX_LOG2) ? MAX_LOG2 : l;
    pe = 1'b0;
    if (pw) m_p = pd & span(m_l);
    else if (pi) begin
      if (m_full) pe = 1'b1; else m_p = (m_p + 1) & span(m_l);
    end
    if (cw) begin
      m_c = cd & span(m_l); m_err = cd[30:24];
    end else if (ci) begin
      if (m_empty) pe = 1'b1; else m_c = (m_c + 1) & span(m_l);
    end
    m_empty = (((m_p ^ m_c) & span(m_l)) == 0);
    m_full  = (((m_p ^ m_c) & span(m_l)) == (span(m_l) ^ (span(m_l) >> 1)));
    x.due = cyc_n + 1; x.tag = tag;
    x.p = m_p; x.c = {1'b0, m_err, 24'(m_c)};
    x.f = m_full; x.e = m_empty; x.pe = pe;
    x.ps = slot_of(m_p, m_l); x.cs = slot_of(m_c, m_l);
    sbq.push_back(x);
  endtask

  task automatic idle(input string tag);
    cyc(q_en, int'(log2_size), 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compares the oldest due item half a cycle after the edge
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc_n) begin
      exp_t x;
      x = sbq.pop_front();
      n_checks++;
      if (prod_reg !== x.p || cons_reg !== x.c || q_full !== x.f || q_empty !== x.e ||
          proto_err !== x.pe || prod_slot !== x.ps || cons_slot !== x.cs) begin
        n_errors++;
        $display("FAIL %s: act p=%h c=%h f=%b e=%b pe=%b ps=%h cs=%h exp p=%h c=%h f=%b e=%b pe=%b ps=%h cs=%h",
                 x.tag, prod_reg, cons_reg, q_full, q_empty, proto_err, prod_slot, cons_slot,
                 x.p, x.c, x.f, x.e, x.pe, x.ps, x.cs);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #200000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: act running exp done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;  // R1 reset state
    if (prod_reg !== 0 || cons_reg !== 0 || q_full !== 0 || q_empty !== 1 ||
        proto_err !== 0 || prod_slot !== 0 || cons_slot !== 0) begin
      n_errors++;
      $display("FAIL R1: act p=%h c=%h f=%b e=%b pe=%b exp p=0 c=0 f=0 e=1 pe=0",
               prod_reg, cons_reg, q_full, q_empty, proto_err);
    end
    rst = 1'b0;

    cyc(0, 2, 0, 0, 0, 0, 0, 0, "R2 capture L=2");
    cyc(1, 2, 0, 0, 0, 0, 0, 0, "R3 empty R7 slot base");
    for (int i = 0; i < 4; i++) cyc(1, 2, 0, 0, 0, 0, 1, 0, "R4 fill R11");
    cyc(1, 2, 0, 0, 0, 0, 1, 0, "R9 push while full");
    idle("R9 pulse lasts one cycle");
    for (int i = 0; i < 4; i++) cyc(1, 2, 0, 0, 0, 0, 0, 1, "R3 drain R7");
    cyc(1, 2, 0, 0, 0, 0, 0, 1, "R9 pop while empty");
    for (int i = 0; i < 4; i++) cyc(1, 2, 0, 0, 0, 0, 1, 0, "R5 wrap to zero");
    for (int i = 0; i < 4; i++) cyc(1, 2, 0, 0, 0, 0, 0, 1, "R5 consumer wrap");
    cyc(1, 2, 0, 0, 1, 32'h5A00_0003, 0, 0, "R8 consumer write with code");
    cyc(1, 2, 1, 32'hFFFF_FFF3, 0, 0, 0, 0, "R8 producer write masked");
    cyc(1, 2, 0, 0, 0, 0, 1, 0, "R6 push");
    cyc(1, 2, 0, 0, 0, 0, 0, 1, "R6 pop keeps code");
    cyc(1, 2, 0, 0, 0, 0, 1, 0, "R10 prep");
    cyc(1, 2, 0, 0, 0, 0, 1, 1, "R10 both advance");
    cyc(1, 2, 1, 32'h1, 0, 0, 1, 0, "R10 write beats push");
    cyc(1, 2, 0, 0, 1, 32'h0100_0002, 0, 1, "R10 write beats pop");
    cyc(1, 3, 1, 0, 1, 0, 0, 0, "R2 size change while enabled");
    for (int i = 0; i < 4; i++) cyc(1, 3, 0, 0, 0, 0, 1, 0, "R2 depth unchanged");
    cyc(0, 15, 1, 32'hFFFF, 0, 0, 0, 0, "R2 clamp R7 high slot");
    cyc(0, 15, 0, 0, 1, 32'h0000_00FF, 0, 0, "R4 full at L=8");
    idle("R11 hold");
    idle("R11 hold");
    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      n_checks++; n_errors++;
      $display("FAIL R11: act %0d pending exp 0", sbq.size());
    end
    finish_run();
  end
endmodule